// File: doc/BRIEF.md
# Over-Clock Recovery Watchdog

This block guards a programmable clock generator against an over-clocking setting that leaves the system hung. Software enables it, programs a timeout in whole seconds and then kicks it periodically. If no kick or timeout reload arrives before the programmed number of seconds has elapsed, the block takes three actions on the same clock edge. It overrides the frequency-select output with a stored safe code. It latches a sticky status bit. It starts a fixed-width pulse that pulls the system reset line low.

The reset output is a pull-down enable for an open-drain pad: high means "drive the line low", low means "release it to the external pull-up". A shared prescaler derives millisecond and second ticks from the input clock. The prescaler restarts whenever the countdown is reloaded and whenever a pulse starts, so both the timeout and the pulse width are exact cycle counts. The timeout register and the control word are read back unchanged. The control word holds the enable bit, the status bit and the safe code.

Top module: `overclock_watchdog`

## Requirements
- R1: In reset and on the first cycle after it, `tmo_rd` reads 0x10 (16 s), `ctl_rd` reads all zeros and `rst_pull_low` is 0.
- R2: While enabled and no pulse is running, with no further reload, expiry (`rst_pull_low` rising) occurs exactly N×S clock edges after the reload edge. N is the timeout value and S = (CLK_HZ/1000)×MS_PER_SEC cycles per second.
- R3: Each of the following reloads the countdown from the timeout value: a `kick`, a `tmo_wr`, or a control write that changes enable from 0 to 1. A reload on the same edge as a pending expiry prevents that expiry.
- R4: A timeout value of 0 leaves the countdown stopped, and no expiry ever happens.
- R5: A control write with enable 0 stops the countdown and leaves the status bit as it was. Kicks while disabled cause no expiry.
- R6: Expiry sets the status bit (ctl bit 1). Only a control write with bit 1 = 0 clears it. A write with bit 1 = 1 never sets it.
- R7: `rst_pull_low` stays high for exactly PULSE_MS×(CLK_HZ/1000) cycles per expiry.
- R8: During a pulse, kicks and timeout writes do not reload or retrigger. When the pulse ends, the countdown reloads from the timeout register if enable is 1. If enable is 0, the block stays idle.
- R9: Without an override, `fs_sel` shows `cfg_fs` one edge later. From the expiry edge it shows the safe code. The override ends on a status-clearing control write or on `cfg_fs_wr`.
- R10: The control word layout is: bit 0 enable, bit 1 status, bits [FS_W+1:2] safe code. `ctl_rd` returns enable and safe code exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmo_wr | input | 1 | Timeout register write strobe |
| tmo_wdata | input | TMO_W | Timeout value in seconds |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | FS_W+2 | Control word: enable, status, safe code |
| kick | input | 1 | Service pulse that restarts the countdown |
| cfg_fs_wr | input | 1 | New frequency configuration written; ends the override |
| cfg_fs | input | FS_W | Normal frequency-select code |
| tmo_rd | output | TMO_W | Timeout register readback |
| ctl_rd | output | FS_W+2 | Control word readback |
| fs_sel | output | FS_W | Registered frequency-select output |
| rst_pull_low | output | 1 | 1 = pull the system reset line low |

## Verification
The assertions assume that reset is applied only before any pulse, because a reset in the middle of a pulse would cut the width the pulse-length check expects. They also assume PULSE_MS is at least 1. The bench raises reset only at the start and holds every strobe for a single cycle. A behavioural model counts remaining cycles directly and is compared on every clock. Directed sequences place a kick on the exact expiry edge, disable the block during a pulse, and use a zero timeout.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // Control word bit positions (readback and write share them)
  localparam int CTL_EN       = 0;
  localparam int CTL_ST       = 1;
  localparam int CTL_SAFE_LSB = 2;

  function automatic int ctl_width(input int fs_w);
    return fs_w + CTL_SAFE_LSB;
  endfunction
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int unsigned CYC_PER_MS = 1000,
  parameter int unsigned MS_PER_SEC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic ms_tick,
  output logic sec_tick
);
  localparam int unsigned MW = (MS_PER_SEC > 1) ? $clog2(MS_PER_SEC) : 1;
  localparam logic [MW-1:0] MS_LAST = MW'(MS_PER_SEC - 1);

  logic [MW-1:0] ms_q;

  generate
    if (CYC_PER_MS > 1) begin : g_div
      localparam int unsigned CW = $clog2(CYC_PER_MS);
      localparam logic [CW-1:0] CYC_LAST = CW'(CYC_PER_MS - 1);
      logic [CW-1:0] cyc_q;
      always_ff @(posedge clk) begin
        if (rst || restart)      cyc_q <= '0;
        else if (cyc_q == CYC_LAST) cyc_q <= '0;
        else                     cyc_q <= cyc_q + 1'b1;
      end
      assign ms_tick = (cyc_q == CYC_LAST);
    end else begin : g_pass
      assign ms_tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || restart) ms_q <= '0;
    else if (ms_tick)   ms_q <= (ms_q == MS_LAST) ? '0 : ms_q + 1'b1;
  end

  assign sec_tick = ms_tick && (ms_q == MS_LAST);
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         stop,
  input  logic         tick,
  output logic         done
);
  logic [W-1:0] cnt_q;
  logic         live_q;

  assign done = live_q && tick && (cnt_q == W'(1)) && !load && !stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      live_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= load_val;
      live_q <= (load_val != '0);
    end else if (stop) begin
      live_q <= 1'b0;
    end else if (live_q && tick) begin
      if (cnt_q == W'(1)) live_q <= 1'b0;
      else                cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdg_pulse_timer.sv
module wdg_pulse_timer #(
  parameter int unsigned PULSE_MS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic ms_tick,
  output logic active,
  output logic done
);
  localparam int unsigned PW = $clog2(PULSE_MS + 1);
  localparam logic [PW-1:0] PULSE_INIT = PW'(PULSE_MS);

  logic [PW-1:0] left_q;

  assign done = active && ms_tick && (left_q == PW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      left_q <= '0;
    end else if (fire) begin
      active <= 1'b1;
      left_q <= PULSE_INIT;
    end else if (done) begin
      active <= 1'b0;
    end else if (active && ms_tick) begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/overclock_watchdog.sv
module overclock_watchdog
  import wdg_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 14_318_000,
  parameter int unsigned MS_PER_SEC = 1000,
  parameter int unsigned PULSE_MS   = 32,
  parameter int unsigned TMO_W      = 8,
  parameter logic [TMO_W-1:0] TMO_RST = TMO_W'(16),
  parameter int unsigned FS_W       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tmo_wr,
  input  logic [TMO_W-1:0]  tmo_wdata,
  input  logic              ctl_wr,
  input  logic [FS_W+1:0]   ctl_wdata,
  input  logic              kick,
  input  logic              cfg_fs_wr,
  input  logic [FS_W-1:0]   cfg_fs,
  output logic [TMO_W-1:0]  tmo_rd,
  output logic [FS_W+1:0]   ctl_rd,
  output logic [FS_W-1:0]   fs_sel,
  output logic              rst_pull_low
);
  localparam int unsigned CYC_PER_MS = (CLK_HZ >= 1000) ? CLK_HZ / 1000 : 1;
  localparam int unsigned SAFE_MSB   = CTL_SAFE_LSB + FS_W - 1;

  logic [TMO_W-1:0] tmo_q, tmo_nxt;
  logic             en_q, en_nxt, st_q, ovr_q, ovr_nxt;
  logic [FS_W-1:0]  safe_q, safe_nxt, fs_q;
  logic             ms_tick, sec_tick, restart;
  logic             reload, expire, en_rise, st_clr;
  logic             pw_active, pw_done;

  assign en_nxt   = ctl_wr ? ctl_wdata[CTL_EN] : en_q;
  assign tmo_nxt  = tmo_wr ? tmo_wdata : tmo_q;
  assign safe_nxt = ctl_wr ? ctl_wdata[SAFE_MSB:CTL_SAFE_LSB] : safe_q;
  assign en_rise  = ctl_wr && ctl_wdata[CTL_EN] && !en_q;
  assign st_clr   = ctl_wr && !ctl_wdata[CTL_ST];

  // A pulse blocks every service request; its end re-arms when enabled
  assign reload  = (!pw_active && en_nxt && (kick || tmo_wr || en_rise)) ||
                   (pw_done && en_nxt);
  assign restart = reload || expire;
  assign ovr_nxt = expire ? 1'b1 : ((st_clr || cfg_fs_wr) ? 1'b0 : ovr_q);

  wdg_prescaler #(.CYC_PER_MS(CYC_PER_MS), .MS_PER_SEC(MS_PER_SEC)) u_pre (
    .clk(clk), .rst(rst), .restart(restart),
    .ms_tick(ms_tick), .sec_tick(sec_tick)
  );

  wdg_countdown #(.W(TMO_W)) u_cd (
    .clk(clk), .rst(rst), .load(reload), .load_val(tmo_nxt),
    .stop(!en_nxt), .tick(sec_tick), .done(expire)
  );

  wdg_pulse_timer #(.PULSE_MS(PULSE_MS)) u_pw (
    .clk(clk), .rst(rst), .fire(expire), .ms_tick(ms_tick),
    .active(pw_active), .done(pw_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_q  <= TMO_RST;
      en_q   <= 1'b0;
      st_q   <= 1'b0;
      safe_q <= '0;
      ovr_q  <= 1'b0;
      fs_q   <= '0;
    end else begin
      tmo_q  <= tmo_nxt;
      en_q   <= en_nxt;
      safe_q <= safe_nxt;
      ovr_q  <= ovr_nxt;
      if (expire)      st_q <= 1'b1;
      else if (st_clr) st_q <= 1'b0;
      fs_q   <= ovr_nxt ? safe_nxt : cfg_fs;
    end
  end

  assign tmo_rd       = tmo_q;
  assign ctl_rd       = {safe_q, st_q, en_q};
  assign fs_sel       = fs_q;
  assign rst_pull_low = pw_active;
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
  import wdg_pkg::*;
#(
  parameter int unsigned TMO_W     = 8,
  parameter logic [TMO_W-1:0] TMO_RST = TMO_W'(16),
  parameter int unsigned FS_W      = 4,
  parameter int unsigned PULSE_CYC = 1
) (
  input logic             clk,
  input logic             rst,
  input logic [TMO_W-1:0] tmo_rd,
  input logic [FS_W+1:0]  ctl_rd,
  input logic [FS_W-1:0]  fs_sel,
  input logic             rst_pull_low
);
  logic [31:0] pw_cnt;

  always_ff @(posedge clk) begin
    if (rst)               pw_cnt <= '0;
    else if (rst_pull_low) pw_cnt <= pw_cnt + 1'b1;
    else                   pw_cnt <= '0;
  end

  // R1
  reset_values_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (tmo_rd == TMO_RST && ctl_rd == '0 && !rst_pull_low));

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst_pull_low) && !$past(rst)) |-> (pw_cnt == 32'(PULSE_CYC)));

  // R6
  status_by_expiry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_rd[CTL_ST]) |-> $rose(rst_pull_low));

  // R9
  safe_on_expiry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_pull_low) |-> (fs_sel == ctl_rd[CTL_SAFE_LSB +: FS_W]));

  // R5
  expiry_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_pull_low) |-> ctl_rd[CTL_EN]);
endmodule

bind overclock_watchdog wdg_checker #(
  .TMO_W(TMO_W), .TMO_RST(TMO_RST), .FS_W(FS_W),
  .PULSE_CYC(CYC_PER_MS * PULSE_MS)
) u_wdg_chk (
  .clk(clk), .rst(rst), .tmo_rd(tmo_rd), .ctl_rd(ctl_rd),
  .fs_sel(fs_sel), .rst_pull_low(rst_pull_low)
);

// File: tb/overclock_watchdog_test.sv
module overclock_watchdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int T_CLK_HZ   = 4000;
  localparam int T_MS_SEC   = 5;
  localparam int T_PULSE_MS = 6;
  localparam int SEC_CYC    = (T_CLK_HZ / 1000) * T_MS_SEC;   // 20
  localparam int PULSE_CYC  = (T_CLK_HZ / 1000) * T_PULSE_MS; // 24

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tmo_wr = 1'b0, ctl_wr = 1'b0, kick = 1'b0, cfg_fs_wr = 1'b0;
  logic [7:0] tmo_wdata = '0;
  logic [5:0] ctl_wdata = '0;
  logic [3:0] cfg_fs = 4'd3;
  logic [7:0] tmo_rd;
  logic [5:0] ctl_rd;
  logic [3:0] fs_sel;
  logic       rst_pull_low;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  overclock_watchdog #(
    .CLK_HZ(T_CLK_HZ), .MS_PER_SEC(T_MS_SEC), .PULSE_MS(T_PULSE_MS),
    .TMO_W(8), .TMO_RST(8'h10), .FS_W(4)
  ) uut (
    .clk(clk), .rst(rst), .tmo_wr(tmo_wr), .tmo_wdata(tmo_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .kick(kick),
    .cfg_fs_wr(cfg_fs_wr), .cfg_fs(cfg_fs), .tmo_rd(tmo_rd),
    .ctl_rd(ctl_rd), .fs_sel(fs_sel), .rst_pull_low(rst_pull_low)
  );

  // Behavioural reference: remaining cycles kept as plain integers
  bit       m_en, m_st, m_live, m_pulse, m_ovr;
  bit [3:0] m_safe, m_fs;
  bit [7:0] m_tmo;
  int       m_rem, m_prem;

  always @(posedge clk) begin : ref_model
    bit       en_n, reload, expire, pend, st_clr;
    bit [7:0] tmo_n;
    if (rst) begin
      m_en = 0; m_st = 0; m_safe = 0; m_tmo = 8'h10; m_live = 0; m_rem = 0;
      m_pulse = 0; m_prem = 0; m_ovr = 0; m_fs = 0;
    end else begin
      en_n   = ctl_wr ? ctl_wdata[0] : m_en;
      tmo_n  = tmo_wr ? tmo_wdata : m_tmo;
      pend   = m_pulse && (m_prem == 1);
      reload = (!m_pulse && en_n && (kick || tmo_wr || (ctl_wr && ctl_wdata[0] && !m_en)))
               || (pend && en_n);
      expire = !reload && en_n && m_live && (m_rem == 1);
      st_clr = ctl_wr && !ctl_wdata[1];
      if (reload) begin
        m_live = (tmo_n != 0);
        m_rem  = int'(tmo_n) * SEC_CYC;
      end else if (!en_n || expire) m_live = 0;
      else if (m_live) m_rem = m_rem - 1;
      if (expire) begin m_pulse = 1; m_prem = PULSE_CYC; end
      else if (pend) m_pulse = 0;
      else if (m_pulse) m_prem = m_prem - 1;
      if (expire) m_st = 1; else if (st_clr) m_st = 0;
      if (expire) m_ovr = 1; else if (st_clr || cfg_fs_wr) m_ovr = 0;
      if (ctl_wr) m_safe = ctl_wdata[5:2];
      m_en  = en_n;
      m_tmo = tmo_n;
      m_fs  = m_ovr ? m_safe : cfg_fs;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    checks++;
    if (rst_pull_low !== m_pulse) begin
      failures++; $display("FAIL R7 model pull actual=%0d expected=%0d", rst_pull_low, m_pulse);
    end
    if (ctl_rd !== {m_safe, m_st, m_en}) begin
      failures++; $display("FAIL R10 model ctl actual=%0h expected=%0h", ctl_rd, {m_safe, m_st, m_en});
    end
    if (fs_sel !== m_fs) begin
      failures++; $display("FAIL R9 model fs actual=%0d expected=%0d", fs_sel, m_fs);
    end
    if (tmo_rd !== m_tmo) begin
      failures++; $display("FAIL R10 model tmo actual=%0d expected=%0d", tmo_rd, m_tmo);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
    tmo_wr = 0; ctl_wr = 0; kick = 0; cfg_fs_wr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic ctl(input bit en, input bit st, input bit [3:0] safe);
    ctl_wr = 1; ctl_wdata = {safe, st, en}; tick();
  endtask

  task automatic set_tmo(input bit [7:0] v);
    tmo_wr = 1; tmo_wdata = v; tick();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 0;
    // R1: reset values
    chk(tmo_rd, 16, "R1 tmo"); chk(ctl_rd, 0, "R1 ctl"); chk(rst_pull_low, 0, "R1 pull");
    tick();
    chk(fs_sel, 3, "R9 fs follows cfg");

    // R2 basic expiry with N=2
    ctl(1, 0, 4'hA);
    chk(ctl_rd, 6'b101001, "R10 ctl layout");
    set_tmo(2);
    idle(39); chk(rst_pull_low, 0, "R2 before expiry");
    idle(1);  chk(rst_pull_low, 1, "R2 at expiry");
    chk(ctl_rd[1], 1, "R6 status set"); chk(fs_sel, 4'hA, "R9 safe code");

    // R8: service ignored during the pulse
    kick = 1; tick();
    set_tmo(2);
    idle(20); chk(rst_pull_low, 1, "R8 no restart in pulse");
    idle(1);  chk(rst_pull_low, 1, "R7 last pulse cycle");
    idle(1);  chk(rst_pull_low, 0, "R7 pulse ended");

    // R8 re-arm, R3 kick restarts
    idle(29); kick = 1; tick();
    idle(39); chk(rst_pull_low, 0, "R3 kick delayed expiry");
    idle(1);  chk(rst_pull_low, 1, "R8 rearmed expiry");

    // R8: disabled during pulse -> no re-arm
    ctl(0, 1, 4'hA);
    idle(23); chk(rst_pull_low, 0, "R7 second pulse end");
    idle(60); chk(rst_pull_low, 0, "R8 no rearm when disabled");
    chk(ctl_rd[1], 1, "R6 status sticky"); chk(fs_sel, 4'hA, "R9 override held");

    // R9: new frequency configuration ends the override
    cfg_fs = 4'd5; cfg_fs_wr = 1; tick();
    chk(fs_sel, 5, "R9 cfg write ends override"); chk(ctl_rd[1], 1, "R6 status kept");
    ctl(0, 0, 4'hA); chk(ctl_rd[1], 0, "R6 status cleared");
    ctl(0, 1, 4'hA); chk(ctl_rd[1], 0, "R6 write one does not set");

    // R3: kick on the expiry edge saves it
    ctl(1, 0, 4'h7);
    idle(39); kick = 1; tick();
    chk(rst_pull_low, 0, "R3 kick at expiry edge");
    idle(39); chk(rst_pull_low, 0, "R3 counting again");
    idle(1);  chk(rst_pull_low, 1, "R3 expiry after kick");
    chk(fs_sel, 4'h7, "R9 new safe code");
    idle(24); chk(rst_pull_low, 0, "R7 third pulse end");

    // R5: disable mid count keeps status
    idle(10); ctl(0, 1, 4'h7);
    idle(100); chk(rst_pull_low, 0, "R5 stopped"); chk(ctl_rd[1], 1, "R5 status unchanged");
    kick = 1; tick(); idle(60); chk(rst_pull_low, 0, "R5 kick while disabled");

    // R4: zero timeout never expires
    set_tmo(0); ctl(1, 1, 4'h7);
    idle(100); chk(rst_pull_low, 0, "R4 zero timeout");
    kick = 1; tick(); idle(60); chk(rst_pull_low, 0, "R4 kick with zero");
    set_tmo(1);
    idle(19); chk(rst_pull_low, 0, "R2 N=1 before");
    idle(1);  chk(rst_pull_low, 1, "R2 N=1 expiry");
    chk(ctl_rd, 6'b011111, "R10 readback"); chk(tmo_rd, 1, "R10 tmo readback");
    idle(30);
    finish_run();
  end
endmodule